// File: doc/BRIEF.md
# Single-Precision Exponent Extraction Unit

This unit takes one 32-bit IEEE-754 single-precision operand and returns, also in single-precision form, the value floor(log2(|x|)). For a normal operand this is the unbiased exponent. For a subnormal operand the leading set bit of the fraction is located and the true negative exponent below -126 is produced, so no operand is flushed or faulted. Zero, infinity and NaN operands map to fixed special results. A NaN is returned in quiet form.

Each accepted operation also reports two per-operation flags. The invalid flag marks a signaling-NaN operand. The denormal flag marks a subnormal operand. The unit has a single register stage. An operand is presented with a valid strobe, and its result, its flags and a valid indication appear on the outputs one clock later. Between operations the outputs keep the last result. The integer exponent always lies in the range -149..127, and every integer in that range is exactly representable in single precision. The conversion back to floating point therefore needs no rounding.

Top module: `getexp_unit`

## Requirements
- R1: After reset `res_valid_o`, `res_o`, `flag_invalid_o` and `flag_denorm_o` are all 0. `res_valid_o` is `op_valid_i` delayed by exactly one clock.
- R2: The sign bit of a zero, subnormal, normal or infinite operand has no effect on the result or the flags.
- R3: A normal operand (exponent field 1..254) yields the exponent field minus 127 as an exact single-precision value. Field 127 yields +0.0 (0x00000000).
- R4: A subnormal operand (exponent field 0, fraction f nonzero) yields p-149 as a single-precision value, where p is the bit index (0..22) of the highest set bit of f.
- R5: A NaN operand (exponent field 255, fraction nonzero) yields the same word with fraction bit 22 forced to 1. The sign and all other fraction bits are kept.
- R6: An infinite operand of either sign yields +infinity (0x7F800000).
- R7: A zero operand of either sign yields -infinity (0xFF800000).
- R8: `flag_invalid_o` is 1 exactly when the operand was a signaling NaN, that is a NaN with fraction bit 22 equal to 0.
- R9: `flag_denorm_o` is 1 exactly when the operand was subnormal.
- R10: In a cycle where `op_valid_i` is low, `res_o` and both flags keep their values on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operand strobe |
| op_i | input | 32 | Single-precision operand |
| res_valid_o | output | 1 | Result strobe, one clock after `op_valid_i` |
| res_o | output | 32 | floor(log2(\|x\|)) as single precision, or a special result |
| flag_invalid_o | output | 1 | Operand was a signaling NaN |
| flag_denorm_o | output | 1 | Operand was subnormal |

## Verification
All internal state sits in the single result register. A fault in operand classification, in the leading-one search or in the integer-to-float packing therefore shows on `res_o` or on the flags in the very next cycle after the operand is strobed. The subnormal boundaries need particular care: the fraction with only bit 0 set and the fraction with bit 22 set. The exponent fields 1, 127 and 254 are also boundaries, because an off-by-one there changes the result word rather than a single bit. The hold behaviour is checked one cycle later. At that point a register that reloads when it should hold shows a changed result driven by deliberately scrambled input.

// File: rtl/getexp_pkg.sv
package getexp_pkg;

    localparam int unsigned DEF_EXP_W  = 8;
    localparam int unsigned DEF_FRAC_W = 23;

    typedef enum logic [2:0] {
        OPK_ZERO,
        OPK_SUBN,
        OPK_NORM,
        OPK_INF,
        OPK_QNAN,
        OPK_SNAN
    } opkind_e;

endpackage

// File: rtl/getexp_msb.sv
module getexp_msb #(
    parameter int unsigned W     = 23,
    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    // Walk upward so the highest set bit is the one that remains.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < int'(W); i++) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/getexp_classify.sv
module getexp_classify #(
    parameter int unsigned EXP_W  = getexp_pkg::DEF_EXP_W,
    parameter int unsigned FRAC_W = getexp_pkg::DEF_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-2:0]    mag_i,
    output getexp_pkg::opkind_e  kind_o
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    assign exp_f     = mag_i[WORD_W-2 -: EXP_W];
    assign frac_f    = mag_i[FRAC_W-1:0];
    assign exp_ones  = &exp_f;
    assign exp_zero  = ~|exp_f;
    assign frac_zero = ~|frac_f;

    always_comb begin
        if (exp_zero) begin
            kind_o = frac_zero ? getexp_pkg::OPK_ZERO : getexp_pkg::OPK_SUBN;
        end else if (exp_ones) begin
            if (frac_zero)
                kind_o = getexp_pkg::OPK_INF;
            else if (frac_f[FRAC_W-1])
                kind_o = getexp_pkg::OPK_QNAN;
            else
                kind_o = getexp_pkg::OPK_SNAN;
        end else begin
            kind_o = getexp_pkg::OPK_NORM;
        end
    end

endmodule

// File: rtl/getexp_int2fp.sv
module getexp_int2fp #(
    parameter int unsigned INT_W  = 10,
    parameter int unsigned EXP_W  = getexp_pkg::DEF_EXP_W,
    parameter int unsigned FRAC_W = getexp_pkg::DEF_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
    localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1,
    localparam int unsigned IDX_W  = $clog2(INT_W),
    localparam int unsigned SH_W   = $clog2(FRAC_W + 1)
) (
    input  logic [INT_W-1:0]  val_i,
    output logic [WORD_W-1:0] fp_o
);

    logic              neg;
    logic [INT_W-1:0]  mag;
    logic [IDX_W-1:0]  top_idx;
    logic              nonzero;
    logic [SH_W-1:0]   shamt;
    logic [FRAC_W:0]   aligned;
    logic [EXP_W-1:0]  exp_field;

    assign neg = val_i[INT_W-1];
    assign mag = neg ? (~val_i + 1'b1) : val_i;

    getexp_msb #(.W(INT_W)) u_msb (
        .vec_i (mag),
        .idx_o (top_idx),
        .any_o (nonzero)
    );

    // The magnitude is narrower than the significand, so the shift is exact.
    assign shamt     = SH_W'(FRAC_W) - SH_W'(top_idx);
    assign aligned   = {{(FRAC_W + 1 - INT_W){1'b0}}, mag} << shamt;
    assign exp_field = EXP_W'(BIAS) + EXP_W'(top_idx);

    always_comb begin
        if (nonzero)
            fp_o = {neg, exp_field, aligned[FRAC_W-1:0]};
        else
            fp_o = '0;
    end

endmodule

// File: rtl/getexp_unit.sv
module getexp_unit #(
    parameter int unsigned EXP_W  = getexp_pkg::DEF_EXP_W,
    parameter int unsigned FRAC_W = getexp_pkg::DEF_FRAC_W,
    localparam int unsigned WORD_W  = 1 + EXP_W + FRAC_W,
    localparam int unsigned INT_W   = EXP_W + 2,
    localparam int unsigned BIAS    = (1 << (EXP_W - 1)) - 1,
    localparam int unsigned SUB_OFS = BIAS - 1 + FRAC_W,
    localparam int unsigned FIDX_W  = $clog2(FRAC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [WORD_W-1:0] op_i,
    output logic              res_valid_o,
    output logic [WORD_W-1:0] res_o,
    output logic              flag_invalid_o,
    output logic              flag_denorm_o
);

    localparam logic [WORD_W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-1:0] NEG_INF = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] res;
        logic              inv;
        logic              den;
    } stage_t;

    stage_t stage_d, stage_q;

    getexp_pkg::opkind_e kind;
    logic [FIDX_W-1:0]   lead_idx;
    logic                lead_any;
    logic [INT_W-1:0]    int_exp;
    logic [WORD_W-1:0]   int_fp;
    logic [EXP_W-1:0]    exp_f;
    logic [FRAC_W-1:0]   frac_f;

    assign exp_f  = op_i[WORD_W-2 -: EXP_W];
    assign frac_f = op_i[FRAC_W-1:0];

    getexp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .mag_i  (op_i[WORD_W-2:0]),
        .kind_o (kind)
    );

    getexp_msb #(.W(FRAC_W)) u_lead (
        .vec_i (frac_f),
        .idx_o (lead_idx),
        .any_o (lead_any)
    );

    // Integer exponent in two's complement; only numeric kinds use it.
    always_comb begin
        if (kind == getexp_pkg::OPK_SUBN)
            int_exp = INT_W'(lead_idx) - INT_W'(SUB_OFS);
        else if (kind == getexp_pkg::OPK_NORM)
            int_exp = INT_W'(exp_f) - INT_W'(BIAS);
        else
            int_exp = '0;
    end

    getexp_int2fp #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cvt (
        .val_i (int_exp),
        .fp_o  (int_fp)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = op_valid_i;
        if (op_valid_i) begin
            stage_d.inv = 1'b0;
            stage_d.den = 1'b0;
            unique case (kind)
                getexp_pkg::OPK_ZERO: stage_d.res = NEG_INF;
                getexp_pkg::OPK_INF:  stage_d.res = POS_INF;
                getexp_pkg::OPK_QNAN: stage_d.res = op_i;
                getexp_pkg::OPK_SNAN: begin
                    stage_d.res = op_i | WORD_W'(1) << (FRAC_W - 1);
                    stage_d.inv = 1'b1;
                end
                getexp_pkg::OPK_SUBN: begin
                    stage_d.res = int_fp;
                    stage_d.den = lead_any;
                end
                default:              stage_d.res = int_fp;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    assign res_valid_o    = stage_q.valid;
    assign res_o          = stage_q.res;
    assign flag_invalid_o = stage_q.inv;
    assign flag_denorm_o  = stage_q.den;

    // Assertions
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> res_valid_o);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> !res_valid_o);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> ($stable(res_o) && $stable(flag_invalid_o) && $stable(flag_denorm_o)));
    p_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (&exp_f) && !(|frac_f)) |=> (res_o == POS_INF));
    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !(|op_i[WORD_W-2:0])) |=> (res_o == NEG_INF));
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (&exp_f) && (|frac_f)) |=> (res_o[FRAC_W-1] && (&res_o[WORD_W-2 -: EXP_W])));
    p_inv_only_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !(&exp_f)) |=> !flag_invalid_o);
    p_den_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !(|exp_f) && (|frac_f)) |=> flag_denorm_o);
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !(flag_invalid_o && flag_denorm_o));

endmodule

// File: tb/getexp_unit_tb.sv
`timescale 1ns/100ps
module getexp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [31:0] op_i = '0;
    logic        res_valid_o;
    logic [31:0] res_o;
    logic        flag_invalid_o;
    logic        flag_denorm_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    getexp_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid_i     (op_valid_i),
        .op_i           (op_i),
        .res_valid_o    (res_valid_o),
        .res_o          (res_o),
        .flag_invalid_o (flag_invalid_o),
        .flag_denorm_o  (flag_denorm_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Exact integer to single precision through a double-precision value.
    function automatic logic [31:0] int_to_sp(input int v);
        real         r;
        logic [63:0] b;
        logic [10:0] e11;
        if (v == 0) return 32'h0;
        r   = v;
        b   = $realtobits(r);
        e11 = b[62:52] - 11'd1023 + 11'd127;
        return {b[63], e11[7:0], b[51:29]};
    endfunction

    // Returns {invalid, denormal, result}.
    function automatic logic [33:0] model(input logic [31:0] x);
        logic [7:0]  e = x[30:23];
        logic [22:0] f = x[22:0];
        int          p = 0;
        if (e == 8'hFF) begin
            if (f != 0) return {~f[22], 1'b0, x[31], 8'hFF, 1'b1, f[21:0]};
            return {2'b00, 32'h7F800000};
        end
        if (e == 0) begin
            if (f == 0) return {2'b00, 32'hFF800000};
            for (int i = 0; i < 23; i++) if (f[i]) p = i;
            return {2'b01, int_to_sp(p - 149)};
        end
        return {2'b00, int_to_sp(int'(e) - 127)};
    endfunction

    function automatic string tag_of(input logic [31:0] x);
        if (x[30:23] == 8'hFF) return (x[22:0] != 0) ? "R5" : "R6";
        if (x[30:23] == 8'h00) return (x[22:0] != 0) ? "R4" : "R7";
        return "R3";
    endfunction

    task automatic run_op(input logic [31:0] x, input string tag);
        logic [33:0] m;
        logic [31:0] held;
        m = model(x);
        @(negedge clk);
        op_i       = x;
        op_valid_i = 1'b1;
        @(negedge clk);
        op_valid_i = 1'b0;
        op_i       = $urandom;
        check({"R1 valid ", tag}, {31'd0, res_valid_o}, 32'd1);
        check(tag, res_o, m[31:0]);
        check("R8 invalid", {31'd0, flag_invalid_o}, {31'd0, m[33]});
        check("R9 denormal", {31'd0, flag_denorm_o}, {31'd0, m[32]});
        held = res_o;
        @(negedge clk);
        check("R10 hold", res_o, held);
        check("R10 flags", {30'd0, flag_invalid_o, flag_denorm_o}, {30'd0, m[33], m[32]});
        check("R1 idle", {31'd0, res_valid_o}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'd0, res_valid_o}, 32'd0);
        check("R1 reset res", res_o, 32'd0);
        check("R1 reset flags", {30'd0, flag_invalid_o, flag_denorm_o}, 32'd0);
        rst_n = 1'b1;

        run_op(32'h3F800000, "R3 one gives +0");
        check("R3 literal +0", res_o, 32'h00000000);
        run_op(32'h40000000, "R3 two");
        run_op(32'h3F000000, "R3 half");
        run_op(32'h7F7FFFFF, "R3 max normal");
        check("R3 literal 127", res_o, 32'h42FE0000);
        run_op(32'h00800000, "R3 min normal");
        run_op(32'h00000001, "R4 smallest subnormal");
        check("R4 literal -149", res_o, 32'hC3150000);
        run_op(32'h00400000, "R4 top subnormal");
        check("R4 literal -127", res_o, 32'hC2FE0000);
        run_op(32'h807FFFFF, "R4 negative subnormal");
        run_op(32'h00000000, "R7 +0");
        run_op(32'h80000000, "R7 -0");
        run_op(32'h7F800000, "R6 +inf");
        run_op(32'hFF800000, "R6 -inf");
        run_op(32'h7F800001, "R5 signaling NaN");
        check("R5 literal quiet", res_o, 32'h7FC00001);
        run_op(32'hFFC00123, "R5 quiet NaN");
        run_op(32'hC1000000, "R2 negative eight");
        check("R2 sign ignored", res_o, 32'h40400000);

        for (int n = 0; n < 3000; n++) begin
            int unsigned sel = $urandom % 6;
            x = $urandom;
            case (sel)
                0: x[30:23] = 8'(1 + ($urandom % 254));
                1: begin
                    x[30:23] = 8'h00;
                    x[22:0]  = 23'($urandom) >> ($urandom % 23);
                    if (x[22:0] == 0) x[0] = 1'b1;
                end
                2: x[30:0] = '0;
                3: begin x[30:23] = 8'hFF; x[22:0] = '0; end
                4: begin
                    x[30:23] = 8'hFF;
                    if (x[22:0] == 0) x[3] = 1'b1;
                end
                default: ;
            endcase
            run_op(x, tag_of(x));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule